// File: doc/BRIEF.md
# Pipeline Operand Bypass Unit

This block chooses the two ALU operands for the instruction entering the execute stage of a five-stage in-order integer pipeline. An instruction one or two places ahead may still hold a result that the register file does not yet contain. For each source register the unit compares the register number with the destination numbers held in the EX/MEM and MEM/WB pipeline registers. It then passes on either the value read from the register file during decode, the ALU result waiting in EX/MEM, or the value waiting in MEM/WB. The MEM/WB value is the load data for a load and the ALU result otherwise. Each operand also gets a two-bit code that says which path was taken.

The unit holds the register file as well. The writeback stage writes it, and the decode stage reads it through two ports. A write is visible to a read of the same register in the same cycle. An instruction three places behind its producer therefore gets the new value with no bypass path. A store sitting in EX/MEM takes its write data from MEM/WB when the instruction ahead of it is writing the register that holds the data. This covers a load followed directly by a store of the loaded value. Hazard detection and stalls, the ALU and the memories are outside this block.

Top module: `operand_bypass`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero on both decode read ports.
- R2: Register 0 always reads zero on the decode ports, and a writeback to register 0 is discarded. An execute-stage source of register 0 gives select code 2'b00 and an operand of zero, whatever the pipeline registers hold.
- R3: A writeback (MEM/WB write enable set, destination nonzero) writes the writeback value, which is the load data when the MEM/WB load flag is set and the ALU result otherwise. A decode read of that register in the same cycle already returns the new value, and the value stays readable in later cycles.
- R4: When the EX/MEM write enable is set, its load flag is clear, and its destination equals a nonzero source, that operand gets select code 2'b10 and the EX/MEM ALU result.
- R5: When the MEM/WB write enable is set and its destination equals a nonzero source, and R4 does not apply, that operand gets select code 2'b01 and the writeback value.
- R6: When both EX/MEM and MEM/WB qualify for the same source, EX/MEM wins with code 2'b10.
- R7: A stage whose write enable is clear is never forwarded from. With no qualifying stage, the operand gets code 2'b00 and the register-file value supplied from decode.
- R8: A load held in EX/MEM is never forwarded, because its data does not exist yet. The operand falls through to MEM/WB or to the register file.
- R9: When the EX/MEM instruction is a store, MEM/WB writes a nonzero register, and that register equals the store's data register, the store write data is the writeback value and the store-forward flag is 1. In every other case the write data is the store value carried in EX/MEM and the flag is 0.
- R10: The two operands are selected independently. Code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs_addr | input | AW | First decode read register number |
| id_rt_addr | input | AW | Second decode read register number |
| id_rs_data | output | DW | First decode read value |
| id_rt_data | output | DW | Second decode read value |
| ex_rs_addr | input | AW | First source register of the execute instruction |
| ex_rt_addr | input | AW | Second source register of the execute instruction |
| ex_rs_file | input | DW | Register-file value of the first source, captured in decode |
| ex_rt_file | input | DW | Register-file value of the second source, captured in decode |
| exm_rd | input | AW | EX/MEM destination register |
| exm_we | input | 1 | EX/MEM register-write enable |
| exm_load | input | 1 | EX/MEM holds a load |
| exm_alu | input | DW | EX/MEM ALU result |
| exm_store | input | 1 | EX/MEM holds a store |
| exm_st_rt | input | AW | Data register of the store in EX/MEM |
| exm_st_val | input | DW | Store data carried in EX/MEM |
| mwb_rd | input | AW | MEM/WB destination register |
| mwb_we | input | 1 | MEM/WB register-write enable |
| mwb_load | input | 1 | MEM/WB holds a load |
| mwb_alu | input | DW | MEM/WB ALU result |
| mwb_rdata | input | DW | MEM/WB memory read data |
| op_a_sel | output | 2 | First operand select code (00 file, 10 EX/MEM, 01 MEM/WB) |
| op_a | output | DW | First ALU operand |
| op_b_sel | output | 2 | Second operand select code |
| op_b | output | DW | Second ALU operand |
| st_wdata | output | DW | Store write data for the memory port |
| st_fwd | output | 1 | Store write data came from MEM/WB |

## Verification
Two pairs of functions can act in the same cycle. In the first, both pipeline stages claim the same source register, which is how priority is tested. In the second, a writeback to a register coincides with a decode read of that register, which is how the write-first register file is tested. The bench builds both cases on purpose. It sets equal destinations in EX/MEM and MEM/WB with different values, and it reads a register through decode in the same cycle that MEM/WB writes it. A scoreboard model predicts the code and value, giving EX/MEM precedence and letting the write show through on the read. Each result is judged against that prediction. A short run of random cycles drawn from a small set of register numbers then mixes both cases with store forwarding and load suppression.

// File: rtl/bypass_pkg.sv
// Shared encodings for the operand bypass unit.
// Assumes a two-bit select code; 2'b11 is never produced.
package bypass_pkg;
    typedef enum logic [1:0] {
        SEL_FILE = 2'b00,
        SEL_MWB  = 2'b01,
        SEL_EXM  = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/bypass_regfile.sv
// Register file with NRD read ports and one write port. A write is
// seen by a same-cycle read of the same register (write-first).
// Assumes register 0 is hardwired to zero; writes to it are dropped.
module bypass_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 32,
    parameter int NRD  = 2,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata
);
    logic [DW-1:0] mem [NREG];
    logic          wr_ok;

    // Qualify the write: register 0 is never written.
    always_comb wr_ok = we && (waddr != '0);

    // Storage update, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_ok) begin
            mem[waddr] <= wdata;
        end
    end

    // One read port per generate iteration, with write-first bypass.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (raddr[p] == '0) begin
                rdata[p] = '0;
            end else if (wr_ok && (waddr == raddr[p])) begin
                rdata[p] = wdata;
            end else begin
                rdata[p] = mem[raddr[p]];
            end
        end
    end
endmodule

// File: rtl/bypass_operand_mux.sv
// Select logic for one ALU operand. EX/MEM (younger) wins over MEM/WB.
// Assumes a load in EX/MEM has no data yet and is skipped; stall
// logic elsewhere keeps a dependent instruction out of EX in that case.
module bypass_operand_mux
    import bypass_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [DW-1:0] file_val,
    input  logic [AW-1:0] exm_rd,
    input  logic          exm_we,
    input  logic          exm_load,
    input  logic [DW-1:0] exm_alu,
    input  logic [AW-1:0] mwb_rd,
    input  logic          mwb_we,
    input  logic [DW-1:0] mwb_val,
    output logic [1:0]    sel,
    output logic [DW-1:0] val
);
    logic src_zero;
    logic hit_exm;
    logic hit_mwb;

    // Match detection for each producer stage.
    always_comb begin
        src_zero = (src == '0);
        hit_exm  = exm_we && !exm_load && (exm_rd == src) && !src_zero;
        hit_mwb  = mwb_we && (mwb_rd == src) && !src_zero;
    end

    // Priority select: zero source, EX/MEM, MEM/WB, register file.
    always_comb begin
        if (src_zero) begin
            sel = SEL_FILE;
            val = '0;
        end else if (hit_exm) begin
            sel = SEL_EXM;
            val = exm_alu;
        end else if (hit_mwb) begin
            sel = SEL_MWB;
            val = mwb_val;
        end else begin
            sel = SEL_FILE;
            val = file_val;
        end
    end
endmodule

// File: rtl/bypass_store_path.sv
// Store write-data bypass: a store in EX/MEM takes its data from the
// MEM/WB writeback when MEM/WB writes the store's data register.
// Assumes the writeback value is already load data for a load.
module bypass_store_path #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          exm_store,
    input  logic [AW-1:0] exm_st_rt,
    input  logic [DW-1:0] exm_st_val,
    input  logic [AW-1:0] mwb_rd,
    input  logic          mwb_we,
    input  logic [DW-1:0] mwb_val,
    output logic [DW-1:0] st_wdata,
    output logic          st_fwd
);
    // Detect the dependence and steer the write data.
    always_comb begin
        st_fwd   = exm_store && mwb_we && (mwb_rd != '0) && (mwb_rd == exm_st_rt);
        st_wdata = st_fwd ? mwb_val : exm_st_val;
    end
endmodule

// File: rtl/operand_bypass.sv
// Operand bypass unit for a five-stage in-order pipeline: the write-first
// register file, one select mux per ALU operand and the store data path.
// Assumes the decode-captured file values arrive from the ID/EX register.
module operand_bypass #(
    parameter int DW   = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG),
    localparam int NOP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs_addr,
    input  logic [AW-1:0] id_rt_addr,
    output logic [DW-1:0] id_rs_data,
    output logic [DW-1:0] id_rt_data,
    input  logic [AW-1:0] ex_rs_addr,
    input  logic [AW-1:0] ex_rt_addr,
    input  logic [DW-1:0] ex_rs_file,
    input  logic [DW-1:0] ex_rt_file,
    input  logic [AW-1:0] exm_rd,
    input  logic          exm_we,
    input  logic          exm_load,
    input  logic [DW-1:0] exm_alu,
    input  logic          exm_store,
    input  logic [AW-1:0] exm_st_rt,
    input  logic [DW-1:0] exm_st_val,
    input  logic [AW-1:0] mwb_rd,
    input  logic          mwb_we,
    input  logic          mwb_load,
    input  logic [DW-1:0] mwb_alu,
    input  logic [DW-1:0] mwb_rdata,
    output logic [1:0]    op_a_sel,
    output logic [DW-1:0] op_a,
    output logic [1:0]    op_b_sel,
    output logic [DW-1:0] op_b
    ,
    output logic [DW-1:0] st_wdata,
    output logic          st_fwd
);
    logic [DW-1:0]          wb_val;
    logic [NOP-1:0][AW-1:0] rd_addr;
    logic [NOP-1:0][DW-1:0] rd_data;
    logic [NOP-1:0][AW-1:0] src_addr;
    logic [NOP-1:0][DW-1:0] src_file;
    logic [NOP-1:0][1:0]    src_sel;
    logic [NOP-1:0][DW-1:0] src_val;

    // Writeback value: load data for loads, ALU result otherwise.
    always_comb wb_val = mwb_load ? mwb_rdata : mwb_alu;

    // Pack the per-operand ports into arrays for the generate loop.
    always_comb begin
        rd_addr[0]  = id_rs_addr;
        rd_addr[1]  = id_rt_addr;
        src_addr[0] = ex_rs_addr;
        src_addr[1] = ex_rt_addr;
        src_file[0] = ex_rs_file;
        src_file[1] = ex_rt_file;
    end

    bypass_regfile #(.DW(DW), .NREG(NREG), .NRD(NOP)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mwb_we),
        .waddr (mwb_rd),
        .wdata (wb_val),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    for (genvar k = 0; k < NOP; k++) begin : g_op
        bypass_operand_mux #(.DW(DW), .AW(AW)) u_mux (
            .src      (src_addr[k]),
            .file_val (src_file[k]),
            .exm_rd   (exm_rd),
            .exm_we   (exm_we),
            .exm_load (exm_load),
            .exm_alu  (exm_alu),
            .mwb_rd   (mwb_rd),
            .mwb_we   (mwb_we),
            .mwb_val  (wb_val),
            .sel      (src_sel[k]),
            .val      (src_val[k])
        );
    end

    bypass_store_path #(.DW(DW), .AW(AW)) u_st (
        .exm_store  (exm_store),
        .exm_st_rt  (exm_st_rt),
        .exm_st_val (exm_st_val),
        .mwb_rd     (mwb_rd),
        .mwb_we     (mwb_we),
        .mwb_val    (wb_val),
        .st_wdata   (st_wdata),
        .st_fwd     (st_fwd)
    );

    // Unpack the arrays onto the output ports.
    always_comb begin
        id_rs_data = rd_data[0];
        id_rt_data = rd_data[1];
        op_a_sel   = src_sel[0];
        op_a       = src_val[0];
        op_b_sel   = src_sel[1];
        op_b       = src_val[1];
    end
endmodule

// File: rtl/operand_bypass_chk.sv
// Assertion checker for operand_bypass, attached with bind below.
// Assumes it sees exactly the top-level ports of the unit.
module operand_bypass_chk #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] id_rs_addr,
    input logic [AW-1:0] id_rt_addr,
    input logic [DW-1:0] id_rs_data,
    input logic [DW-1:0] id_rt_data,
    input logic [AW-1:0] ex_rs_addr,
    input logic [AW-1:0] ex_rt_addr,
    input logic [DW-1:0] ex_rs_file,
    input logic [DW-1:0] ex_rt_file,
    input logic [AW-1:0] exm_rd,
    input logic          exm_we,
    input logic          exm_load,
    input logic [DW-1:0] exm_alu,
    input logic          exm_store,
    input logic [AW-1:0] exm_st_rt,
    input logic [DW-1:0] exm_st_val,
    input logic [AW-1:0] mwb_rd,
    input logic          mwb_we,
    input logic          mwb_load,
    input logic [DW-1:0] mwb_alu,
    input logic [DW-1:0] mwb_rdata,
    input logic [1:0]    op_a_sel,
    input logic [DW-1:0] op_a,
    input logic [1:0]    op_b_sel,
    input logic [DW-1:0] op_b,
    input logic [DW-1:0] st_wdata,
    input logic          st_fwd
);
    logic [DW-1:0] wbv;
    logic          past_ok;
    logic          was_rst;

    // Expected writeback value seen by the checker.
    always_comb wbv = mwb_load ? mwb_rdata : mwb_alu;

    // Track whether the previous cycle was in or out of reset.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
        was_rst <= !rst_n;
    end

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (was_rst && !mwb_we) |-> (id_rs_data == '0 && id_rt_data == '0)); // R1

    AST_SRC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs_addr == '0) |-> (op_a_sel == 2'b00 && op_a == '0)); // R2

    AST_EXM_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (exm_we && !exm_load && exm_rd == ex_rt_addr && ex_rt_addr != '0)
        |-> (op_b_sel == 2'b10 && op_b == exm_alu)); // R4

    AST_MWB_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a_sel == 2'b01) |-> (mwb_we && mwb_rd == ex_rs_addr && op_a == wbv)); // R5

    AST_EXM_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (exm_we && !exm_load && mwb_we && exm_rd == mwb_rd && exm_rd == ex_rs_addr
         && ex_rs_addr != '0) |-> (op_a_sel == 2'b10)); // R6

    AST_IDLE_FILE: assert property (@(posedge clk) disable iff (!rst_n)
        (!exm_we && !mwb_we && ex_rs_addr != '0 && ex_rt_addr != '0)
        |-> (op_a == ex_rs_file && op_b == ex_rt_file)); // R7

    AST_LOAD_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        exm_load |-> (op_a_sel != 2'b10 && op_b_sel != 2'b10)); // R8

    AST_STORE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        st_fwd |-> (exm_store && st_wdata == wbv)); // R9

    AST_STORE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !exm_store |-> (!st_fwd && st_wdata == exm_st_val)); // R9

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a_sel != 2'b11 && op_b_sel != 2'b11)); // R10

    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mwb_we && mwb_rd != '0) && id_rs_addr == $past(mwb_rd)
         && !(mwb_we && mwb_rd == id_rs_addr)) |-> (id_rs_data == $past(wbv))); // R3

    AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (mwb_we && mwb_rd != '0 && id_rt_addr == mwb_rd) |-> (id_rt_data == wbv)); // R3
endmodule

bind operand_bypass operand_bypass_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/operand_bypass_test.sv
`timescale 1ns/1ps
module operand_bypass_test;
    localparam int DW = 32;
    localparam int AW = 5;

    typedef struct {
        string         tag;
        logic [DW-1:0] id_rs, id_rt;
        logic [1:0]    sa, sb;
        logic [DW-1:0] a, b;
        logic [DW-1:0] st;
        logic          sf;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_rs_addr = '0, id_rt_addr = '0;
    logic [DW-1:0] id_rs_data, id_rt_data;
    logic [AW-1:0] ex_rs_addr = '0, ex_rt_addr = '0;
    logic [DW-1:0] ex_rs_file = '0, ex_rt_file = '0;
    logic [AW-1:0] exm_rd = '0;
    logic          exm_we = 1'b0, exm_load = 1'b0, exm_store = 1'b0;
    logic [DW-1:0] exm_alu = '0;
    logic [AW-1:0] exm_st_rt = '0;
    logic [DW-1:0] exm_st_val = '0;
    logic [AW-1:0] mwb_rd = '0;
    logic          mwb_we = 1'b0, mwb_load = 1'b0;
    logic [DW-1:0] mwb_alu = '0, mwb_rdata = '0;
    logic [1:0]    op_a_sel, op_b_sel;
    logic [DW-1:0] op_a, op_b, st_wdata;
    logic          st_fwd;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    exp_t sb_q[$];
    logic [DW-1:0] mrf [32];

    always #2.5 clk = ~clk;

    operand_bypass #(.DW(DW), .NREG(32)) uut (.*);

    function automatic logic [DW-1:0] wbv();
        return mwb_load ? mwb_rdata : mwb_alu;
    endfunction

    function automatic logic [DW-1:0] rf_read(logic [AW-1:0] a);
        if (a == 0) return '0;
        if (mwb_we && mwb_rd == a) return wbv();
        return mrf[a];
    endfunction

    // Expected operand from the requirement text (R2, R4 to R8).
    task automatic pick(input logic [AW-1:0] s, input logic [DW-1:0] f,
                        output logic [1:0] sel, output logic [DW-1:0] v);
        if (s == 0) begin sel = 2'b00; v = '0; end
        else if (exm_we && !exm_load && exm_rd == s) begin sel = 2'b10; v = exm_alu; end
        else if (mwb_we && mwb_rd == s) begin sel = 2'b01; v = wbv(); end
        else begin sel = 2'b00; v = f; end
    endtask

    // Driver: predict the outputs for the applied inputs, queue them, advance.
    task automatic step(input string tag);
        exp_t e;
        e.tag   = tag;
        e.id_rs = rf_read(id_rs_addr);
        e.id_rt = rf_read(id_rt_addr);
        pick(ex_rs_addr, ex_rs_file, e.sa, e.a);
        pick(ex_rt_addr, ex_rt_file, e.sb, e.b);
        e.sf = exm_store && mwb_we && mwb_rd != 0 && mwb_rd == exm_st_rt;
        e.st = e.sf ? wbv() : exm_st_val;
        sb_q.push_back(e);
        @(posedge clk);
        if (rst_n && mwb_we && mwb_rd != 0) mrf[mwb_rd] = wbv();
        #1;
    endtask

    task automatic idle();
        exm_we = 0; exm_load = 0; exm_store = 0; mwb_we = 0; mwb_load = 0;
    endtask

    task automatic fail1(input string tag, input string f, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        $display("FAIL %s field %s actual %h expected %h", tag, f, act, exp);
    endtask

    // Monitor: pop one expected item per cycle and compare mid-cycle.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            bit bad;
            e = sb_q.pop_front();
            bad = 1'b0;
            n_cmp++;
            if (id_rs_data !== e.id_rs) begin bad = 1; fail1(e.tag, "id_rs_data", id_rs_data, e.id_rs); end
            if (id_rt_data !== e.id_rt) begin bad = 1; fail1(e.tag, "id_rt_data", id_rt_data, e.id_rt); end
            if (op_a_sel !== e.sa) begin bad = 1; fail1(e.tag, "op_a_sel", {30'd0, op_a_sel}, {30'd0, e.sa}); end
            if (op_a !== e.a) begin bad = 1; fail1(e.tag, "op_a", op_a, e.a); end
            if (op_b_sel !== e.sb) begin bad = 1; fail1(e.tag, "op_b_sel", {30'd0, op_b_sel}, {30'd0, e.sb}); end
            if (op_b !== e.b) begin bad = 1; fail1(e.tag, "op_b", op_b, e.b); end
            if (st_fwd !== e.sf) begin bad = 1; fail1(e.tag, "st_fwd", {31'd0, st_fwd}, {31'd0, e.sf}); end
            if (st_wdata !== e.st) begin bad = 1; fail1(e.tag, "st_wdata", st_wdata, e.st); end
            if (bad) n_bad++;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) mrf[i] = '0;
        // Dirty write attempt during reset, then release.
        mwb_we = 1; mwb_rd = 5'd7; mwb_alu = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        #1;
        idle();
        rst_n = 1;

        // R1: everything reads zero after reset.
        id_rs_addr = 5'd7; id_rt_addr = 5'd31; step("R1 reset read");
        id_rs_addr = 5'd1; id_rt_addr = 5'd16; step("R1 reset read 2");

        // R3: write-first on the same cycle, then held.
        mwb_we = 1; mwb_rd = 5'd5; mwb_alu = 32'h1111_2222;
        id_rs_addr = 5'd5; id_rt_addr = 5'd5; step("R3 same cycle read");
        idle(); step("R3 held after write");
        mwb_we = 1; mwb_load = 1; mwb_rd = 5'd9; mwb_rdata = 32'hA5A5_0009; mwb_alu = 32'h0;
        id_rs_addr = 5'd9; id_rt_addr = 5'd5; step("R3 load writeback");
        idle(); step("R3 load held");

        // R2: register 0 write discarded, source 0 forced to zero.
        mwb_we = 1; mwb_rd = 5'd0; mwb_alu = 32'hFFFF_FFFF;
        id_rs_addr = 5'd0; id_rt_addr = 5'd0; step("R2 write r0");
        idle(); step("R2 read r0 after");
        exm_we = 1; exm_rd = 5'd0; exm_alu = 32'h1234_5678;
        mwb_we = 1; mwb_rd = 5'd0; ex_rs_addr = 5'd0; ex_rt_addr = 5'd0;
        ex_rs_file = 32'h5555_5555; ex_rt_file = 32'h6666_6666; step("R2 ex source zero");
        idle();

        // R4 and R10: EX/MEM forwards operand A only.
        exm_we = 1; exm_rd = 5'd3; exm_alu = 32'h0000_0333;
        ex_rs_addr = 5'd3; ex_rt_addr = 5'd4; ex_rs_file = 32'h1; ex_rt_file = 32'h4444;
        step("R4 exm to A, R10 B from file");
        ex_rs_addr = 5'd4; ex_rt_addr = 5'd3; step("R4 exm to B, R10 A from file");

        // R5: MEM/WB forwards load data, then ALU result.
        idle(); mwb_we = 1; mwb_load = 1; mwb_rd = 5'd6; mwb_rdata = 32'hCAFE_0006; mwb_alu = 32'h7;
        ex_rs_addr = 5'd6; ex_rt_addr = 5'd6; step("R5 mwb load data");
        mwb_load = 0; mwb_rd = 5'd8; mwb_alu = 32'h0808_0808; ex_rs_addr = 5'd2; ex_rt_addr = 5'd8;
        ex_rs_file = 32'h22; step("R5 mwb alu result");

        // R6: both stages match, EX/MEM wins.
        exm_we = 1; exm_rd = 5'd10; exm_alu = 32'h0000_0E0E;
        mwb_we = 1; mwb_rd = 5'd10; mwb_alu = 32'h0000_0B0B;
        ex_rs_addr = 5'd10; ex_rt_addr = 5'd10; step("R6 exm over mwb");

        // R7: disabled stages are ignored.
        idle(); exm_rd = 5'd11; mwb_rd = 5'd11; ex_rs_addr = 5'd11; ex_rt_addr = 5'd11;
        ex_rs_file = 32'h0B0B_0011; ex_rt_file = 32'h0C0C_0011; step("R7 no write enable");

        // R8: load in EX/MEM skipped, falls to MEM/WB, then to file.
        exm_we = 1; exm_load = 1; exm_rd = 5'd12; exm_alu = 32'hBAD0_0012;
        mwb_we = 1; mwb_rd = 5'd12; mwb_alu = 32'h600D_0012;
        ex_rs_addr = 5'd12; ex_rt_addr = 5'd12; step("R8 exm load to mwb");
        mwb_we = 0; ex_rs_file = 32'hF11E_0012; ex_rt_file = 32'hF11E_0013; step("R8 exm load to file");

        // R9: load followed by store of the loaded register.
        idle(); exm_store = 1; exm_st_rt = 5'd13; exm_st_val = 32'h0101_0101;
        mwb_we = 1; mwb_load = 1; mwb_rd = 5'd13; mwb_rdata = 32'h5700_0013;
        step("R9 store data forwarded");
        mwb_rd = 5'd14; step("R9 store other register");
        mwb_we = 0; mwb_rd = 5'd13; step("R9 store no write enable");
        mwb_we = 1; exm_store = 0; step("R9 not a store");
        exm_store = 1; exm_st_rt = 5'd0; mwb_rd = 5'd0; step("R9 store r0");

        // Random mix over a small register set.
        idle();
        for (int i = 0; i < 60; i++) begin
            exm_we = $urandom_range(0, 1); exm_load = ($urandom_range(0, 3) == 0);
            exm_store = $urandom_range(0, 1); mwb_we = $urandom_range(0, 1);
            mwb_load = $urandom_range(0, 1);
            exm_rd = 5'($urandom_range(0, 3)); mwb_rd = 5'($urandom_range(0, 3));
            exm_st_rt = 5'($urandom_range(0, 3));
            ex_rs_addr = 5'($urandom_range(0, 3)); ex_rt_addr = 5'($urandom_range(0, 3));
            id_rs_addr = 5'($urandom_range(0, 3)); id_rt_addr = 5'($urandom_range(0, 3));
            exm_alu = $urandom; mwb_alu = $urandom; mwb_rdata = $urandom;
            ex_rs_file = $urandom; ex_rt_file = $urandom; exm_st_val = $urandom;
            step("R6 random mix");
        end

        @(negedge clk);
        #1;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule